// File: doc/BRIEF.md
# Channel-Gain Scan-List Sequencer

This block sits in front of an analog-input converter. It keeps a small list of channel and gain selections and walks through that list, one entry for each conversion request. For each request it presents the chosen channel and gain to the external multiplexer and amplifier, together with a one-cycle start pulse. The converter is modelled as a result port. Each result it returns is recoded if required and placed in a result queue. Software reads the queue from the head. A status word reports whether data is waiting, whether a result was lost because the queue was full, and whether a request arrived while a conversion was still in flight. An interrupt request can be raised each time a result is stored.

Software drives the block through a byte-wide register write port. It first sets a list pointer, then writes the entry for that slot. Two control registers select scanning, result coding and interrupt enables. Three strobe addresses act on any write, whatever the data: start a conversion, clear the queue, and drop the interrupt. In scan mode the sequencer steps on every accepted request and returns to slot 0 after the entry marked as the end of the scan. In single mode it keeps applying the same slot.

Top module: `chgain_scan_seq`

## Requirements
- R1: A write to register address 3 stores an entry in the list slot last written to register address 2 (pointer in data bits 3:0). The entry holds the channel in bits 3:0, an end-of-scan mark in bit 4 and the gain code in bits 7:6.
- R2: A write to address 4 (convert) that arrives while no conversion is in flight produces `conv_start` high for exactly the following cycle. At the same time `conv_chan` and `conv_gain` show the entry at the current sequencer slot.
- R3: When control register A (address 0) bit 3 is set, each accepted conversion moves the sequencer to the next slot. After a slot carrying the end-of-scan mark, or after slot 15, it returns to slot 0.
- R4: When control register A bit 3 is clear, accepted conversions do not move the sequencer, so the same entry is applied every time.
- R5: Writing 0 to address 2 returns the sequencer to slot 0. Writing a non-zero value changes only the list write slot and leaves the sequencer where it is.
- R6: While `diff_wiring` is 1, bit 3 of `conv_chan` is forced to 0, which leaves 8 usable channels.
- R7: Converter results are queued in arrival order, up to 16 words. `rd_data` shows the oldest word. `rd_pop` removes it. `status` bit 13 is 1 while the queue is not empty.
- R8: A result that arrives while the queue holds 16 words is discarded and sets `status` bit 9.
- R9: A convert write that arrives while a conversion is in flight (from an accepted request until `conv_valid`) is ignored: no start pulse is produced and the sequencer does not move. It also sets `status` bit 8.
- R10: When control register A bit 0 is 0, bit 11 of each stored result is inverted. When it is 1, the result is stored unchanged.
- R11: Any write to address 5 empties the queue and clears `status` bits 8 and 9.
- R12: `irq` goes to 1 when a result is stored while control register A bit 7 and control register B (address 1) bit 7 are both 1. It stays at 1 until any write to address 6. No other event raises it.
- R13: After reset, `status`, `irq` and `conv_start` are all 0. Both control registers are 0 and the sequencer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| diff_wiring | input | 1 | 1 selects differential inputs (8 channels) |
| conv_valid | input | 1 | Converter result valid |
| conv_data | input | 12 | Converter result |
| rd_pop | input | 1 | Remove the head word from the result queue |
| rd_data | output | 12 | Head word of the result queue |
| status | output | 16 | Bit 13 data available, bit 9 overflow, bit 8 overrun |
| conv_start | output | 1 | One-cycle conversion start |
| conv_chan | output | 4 | Multiplexer channel for the started conversion |
| conv_gain | output | 2 | Gain code for the started conversion |
| irq | output | 1 | Conversion interrupt request |

## Verification
The embedded properties watch, on every cycle, the rules that follow one clock edge to the next: the sequencer holds still in single mode, it jumps to slot 0 after an end-of-scan entry or a rewind, start pulses never come back to back, and a full queue or a request during a busy conversion sets its flag. They also check the queue count bound, that a clear empties the queue, and where the interrupt comes from and how it is dropped. Only the bench scenarios can show whole-sequence behaviour. That covers the exact order of channels across a scan and its wrap at 15, the differential masking, the recoding of bit 11, and the order of stored results. It also covers which single result is lost on overflow and that an ignored request really left the sequencer untouched.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  localparam int RES_W = 12;

  typedef enum logic [2:0] {
    REG_CTRL_A    = 3'd0,
    REG_CTRL_B    = 3'd1,
    REG_LIST_PTR  = 3'd2,
    REG_LIST_DATA = 3'd3,
    REG_CONVERT   = 3'd4,
    REG_CLEAR     = 3'd5,
    REG_INT_CLR   = 3'd6
  } reg_sel_e;

  localparam int A_STRAIGHT = 0;
  localparam int A_SCAN_EN  = 3;
  localparam int A_CONV_IE  = 7;
  localparam int B_IRQ_EN   = 7;
  localparam int ST_OVERRUN  = 8;
  localparam int ST_OVERFLOW = 9;
  localparam int ST_AVAIL    = 13;

  typedef struct packed {
    logic [1:0] gain;
    logic       last;
    logic [3:0] chan;
  } entry_t;

  function automatic entry_t make_entry(input logic [1:0] g, input logic l, input logic [3:0] c);
    entry_t e;
    e.gain = g;
    e.last = l;
    e.chan = c;
    return e;
  endfunction

  function automatic logic [RES_W-1:0] recode_result(input logic [RES_W-1:0] raw, input logic straight);
    logic [RES_W-1:0] flip;
    flip = '0;
    flip[RES_W-1] = ~straight;
    return raw ^ flip;
  endfunction
endpackage

// File: rtl/cgs_scan_list.sv
module cgs_scan_list
  import cgs_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_entry,
  input  logic             rewind,
  input  logic             step,
  input  logic             scan_en,
  output entry_t           cur_entry,
  output logic [IDX_W-1:0] seq_idx
);
  entry_t           slots_q [ENTRIES];
  logic [IDX_W-1:0] seq_idx_q;
  logic             wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) slots_q[i] <= '0;
    end else if (wr_en) begin
      slots_q[wr_idx] <= wr_entry;
    end
  end

  assign cur_entry = slots_q[seq_idx_q];
  assign wrap      = cur_entry.last || (seq_idx_q == IDX_W'(ENTRIES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                seq_idx_q <= '0;
    else if (rewind)           seq_idx_q <= '0;
    else if (step && scan_en)  seq_idx_q <= wrap ? '0 : seq_idx_q + 1'b1;
  end

  assign seq_idx = seq_idx_q;

  assert_hold_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !scan_en && !rewind) |=> $stable(seq_idx_q));
  assert_wrap_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && scan_en && !rewind && cur_entry.last) |=> (seq_idx_q == '0));
  assert_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (seq_idx_q == '0));
endmodule

// File: rtl/cgs_result_fifo.sv
module cgs_result_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 12,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         overflow,
  output logic         push_ok
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] count_q;
  logic             overflow_q, full, pop_ok;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign push_ok = push && !full && !clear;
  assign pop_ok  = pop && (count_q != '0) && !clear;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      count_q    <= '0;
      overflow_q <= 1'b0;
    end else begin
      if (push_ok) wptr_q <= bump(wptr_q);
      if (pop_ok)  rptr_q <= bump(rptr_q);
      count_q    <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      overflow_q <= overflow_q | (push && full);
    end
  end

  assign head      = mem[rptr_q];
  assign not_empty = (count_q != '0);
  assign overflow  = overflow_q;

  assert_no_overfill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    not_empty |-> (count_q <= CNT_W'(DEPTH)));
  assert_overflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clear) |=> overflow_q);
  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!not_empty && !overflow_q));
endmodule

// File: rtl/chgain_scan_seq.sv
module chgain_scan_seq
  import cgs_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             diff_wiring,
  input  logic             conv_valid,
  input  logic [RES_W-1:0] conv_data,
  input  logic             rd_pop,
  output logic [RES_W-1:0] rd_data,
  output logic [15:0]      status,
  output logic             conv_start,
  output logic [3:0]       conv_chan,
  output logic [1:0]       conv_gain,
  output logic             irq
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic             hit_a, hit_b, hit_ptr, hit_data, strobe, clear, int_clr;
  logic             straight_q, scan_en_q, conv_ie_q, irq_en_q;
  logic [IDX_W-1:0] wr_ptr_q, seq_idx;
  entry_t           cur_entry;
  logic             busy_q, accept, overrun_q, irq_q, irq_set;
  logic             stored, not_empty, overflow;
  logic             start_q;
  logic [3:0]       chan_q;
  logic [1:0]       gain_q;

  assign hit_a    = wr_en && (wr_addr == REG_CTRL_A);
  assign hit_b    = wr_en && (wr_addr == REG_CTRL_B);
  assign hit_ptr  = wr_en && (wr_addr == REG_LIST_PTR);
  assign hit_data = wr_en && (wr_addr == REG_LIST_DATA);
  assign strobe   = wr_en && (wr_addr == REG_CONVERT);
  assign clear    = wr_en && (wr_addr == REG_CLEAR);
  assign int_clr  = wr_en && (wr_addr == REG_INT_CLR);
  assign accept   = strobe && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      straight_q <= 1'b0;
      scan_en_q  <= 1'b0;
      conv_ie_q  <= 1'b0;
      irq_en_q   <= 1'b0;
      wr_ptr_q   <= '0;
    end else begin
      if (hit_a) begin
        straight_q <= wr_data[A_STRAIGHT];
        scan_en_q  <= wr_data[A_SCAN_EN];
        conv_ie_q  <= wr_data[A_CONV_IE];
      end
      if (hit_b)   irq_en_q <= wr_data[B_IRQ_EN];
      if (hit_ptr) wr_ptr_q <= wr_data[IDX_W-1:0];
    end
  end

  cgs_scan_list #(.ENTRIES(ENTRIES)) list_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (hit_data),
    .wr_idx    (wr_ptr_q),
    .wr_entry  (make_entry(wr_data[7:6], wr_data[4], wr_data[3:0])),
    .rewind    (hit_ptr && (wr_data == 8'd0)),
    .step      (accept),
    .scan_en   (scan_en_q),
    .cur_entry (cur_entry),
    .seq_idx   (seq_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      overrun_q <= 1'b0;
      start_q   <= 1'b0;
      chan_q    <= '0;
      gain_q    <= '0;
    end else begin
      start_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        chan_q <= {cur_entry.chan[3] & ~diff_wiring, cur_entry.chan[2:0]};
        gain_q <= cur_entry.gain;
      end else if (conv_valid) begin
        busy_q <= 1'b0;
      end
      if (clear)                 overrun_q <= 1'b0;
      else if (strobe && busy_q) overrun_q <= 1'b1;
    end
  end

  cgs_result_fifo #(.DEPTH(FIFO_DEPTH), .W(RES_W)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .push      (conv_valid),
    .push_data (recode_result(conv_data, straight_q)),
    .pop       (rd_pop),
    .head      (rd_data),
    .not_empty (not_empty),
    .overflow  (overflow),
    .push_ok   (stored)
  );

  assign irq_set = stored && conv_ie_q && irq_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (int_clr) irq_q <= 1'b0;
  end

  always_comb begin
    status              = '0;
    status[ST_AVAIL]    = not_empty;
    status[ST_OVERFLOW] = overflow;
    status[ST_OVERRUN]  = overrun_q;
  end

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign conv_gain  = gain_q;
  assign irq        = irq_q;

  assert_single_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && busy_q && !clear) |=> status[ST_OVERRUN]);
  assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(stored && conv_ie_q && irq_en_q));
  assert_irq_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr && !irq_set) |=> !irq);
  assert_busy_blocks_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && busy_q) |=> (!conv_start && $stable(seq_idx)));
endmodule

// File: tb/chgain_scan_seq_tb.sv
module chgain_scan_seq_tb_top;
  import cgs_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, wr_en = 1'b0, diff_wiring = 1'b0, conv_valid = 1'b0, rd_pop = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [11:0] conv_data = '0, rd_data;
  logic [15:0] status;
  logic        conv_start, irq;
  logic [3:0]  conv_chan;
  logic [1:0]  conv_gain;

  chgain_scan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .diff_wiring(diff_wiring), .conv_valid(conv_valid), .conv_data(conv_data),
    .rd_pop(rd_pop), .rd_data(rd_data), .status(status), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_gain(conv_gain), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0, sample_n = 0;
  bit done = 0;
  logic [5:0]  sel_q [$];
  logic [11:0] res_q [$];
  logic [7:0]  m_list [16];
  int          m_idx = 0;
  bit m_scan = 0, m_straight = 0, resp_en = 1, pending = 0, release_req = 0;
  logic [11:0] pend_data;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_push(input logic [11:0] d);
    logic [11:0] r;
    r = m_straight ? d : {~d[11], d[10:0]};
    if (res_q.size() < 16) res_q.push_back(r);
  endtask

  // converter model and scoreboard monitor for start pulses
  initial begin
    forever begin
      @(negedge clk);
      conv_valid = 1'b0;
      if (release_req) begin
        if (pending) begin
          conv_valid = 1'b1;
          conv_data  = pend_data;
          model_push(pend_data);
          pending = 0;
        end
        release_req = 0;
      end
      if (conv_start) begin
        logic [11:0] d;
        if (sel_q.size() == 0) chk("R2", "unexpected start", 1, 0);
        else chk("R2", "chan/gain", {conv_chan, conv_gain}, sel_q.pop_front());
        d = {conv_chan, conv_gain, 6'(sample_n)};
        sample_n++;
        if (resp_en) begin
          conv_valid = 1'b1;
          conv_data  = d;
          model_push(d);
        end else begin
          pending   = 1;
          pend_data = d;
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_a(input logic [7:0] v);
    wr(REG_CTRL_A, v);
    m_scan = v[3];
    m_straight = v[0];
  endtask

  task automatic set_ptr(input int v);
    wr(REG_LIST_PTR, 8'(v));
    if (v == 0) m_idx = 0;
  endtask

  task automatic set_entry(input int idx, input logic [3:0] ch, input logic last, input logic [1:0] g);
    set_ptr(idx);
    wr(REG_LIST_DATA, {g, 1'b0, last, ch});
    m_list[idx] = {g, 1'b0, last, ch};
  endtask

  task automatic strobe(input bit accept);
    if (accept) begin
      logic [7:0] e;
      logic [3:0] ch;
      e  = m_list[m_idx];
      ch = diff_wiring ? {1'b0, e[2:0]} : e[3:0];
      sel_q.push_back({ch, e[7:6]});
      if (m_scan) m_idx = (e[4] || m_idx == 15) ? 0 : m_idx + 1;
    end
    wr(REG_CONVERT, 8'h00);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_one(input string req);
    @(negedge clk);
    chk(req, "avail", status[13], 1);
    if (res_q.size() > 0) chk(req, "rd_data", rd_data, res_q.pop_front());
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic drain(input string req);
    while (res_q.size() > 0) read_one(req);
    @(negedge clk);
    chk(req, "empty after drain", status[13], 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_list[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "status", status, 0);
    chk("R13", "irq", irq, 0);
    chk("R13", "conv_start", conv_start, 0);

    // R1/R3: scan with end-of-scan mark at slot 2
    set_a(8'h09);
    set_entry(0, 4'd5, 0, 2'd1);
    set_entry(1, 4'd9, 0, 2'd2);
    set_entry(2, 4'd12, 1, 2'd3);
    set_entry(3, 4'd7, 0, 2'd0);
    set_ptr(0);
    repeat (4) strobe(1);
    drain("R7");

    // R5: non-zero pointer write keeps position, zero rewinds
    set_ptr(3);
    strobe(1);
    set_ptr(0);
    strobe(1);
    drain("R5");

    // R4: single mode repeats one entry
    set_a(8'h01);
    set_ptr(0);
    repeat (3) strobe(1);
    drain("R4");

    // R6: differential wiring masks channel bit 3
    diff_wiring = 1'b1;
    set_a(8'h09);
    set_ptr(0);
    repeat (3) strobe(1);
    drain("R6");
    diff_wiring = 1'b0;

    // R10: two's-complement coding flips bit 11
    set_a(8'h08);
    set_ptr(0);
    repeat (3) strobe(1);
    drain("R10");

    // R3 wrap at slot 15, R8 overflow on 17th result
    set_a(8'h09);
    for (int i = 0; i < 16; i++) set_entry(i, 4'(i), 0, 2'(i));
    set_ptr(0);
    repeat (17) strobe(1);
    @(negedge clk);
    chk("R8", "overflow flag", status[9], 1);
    drain("R8");
    chk("R8", "overflow held", status[9], 1);

    // R11: clear empties and clears flags
    strobe(1);
    strobe(1);
    wr(REG_CLEAR, 8'h00);
    res_q.delete();
    @(negedge clk);
    chk("R11", "status after clear", status, 0);

    // R9: request during busy conversion is ignored
    resp_en = 0;
    strobe(1);
    strobe(0);
    @(negedge clk);
    chk("R9", "overrun flag", status[8], 1);
    release_req = 1;
    repeat (3) @(negedge clk);
    resp_en = 1;
    strobe(1);
    drain("R9");
    wr(REG_CLEAR, 8'h00);
    @(negedge clk);
    chk("R11", "overrun cleared", status[8], 0);

    // R12: interrupt needs both enables, dropped by clear write
    set_a(8'h89);
    wr(REG_CTRL_B, 8'h00);
    strobe(1);
    chk("R12", "irq one enable only", irq, 0);
    wr(REG_CTRL_B, 8'h80);
    strobe(1);
    chk("R12", "irq raised", irq, 1);
    wr(REG_CTRL_A, 8'h89);
    @(negedge clk);
    chk("R12", "irq held", irq, 1);
    wr(REG_INT_CLR, 8'h00);
    @(negedge clk);
    chk("R12", "irq dropped", irq, 0);
    set_a(8'h09);
    strobe(1);
    chk("R12", "irq with A bit7 clear", irq, 0);
    drain("R12");
    chk("R2", "all starts seen", sel_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule